// File: doc/BRIEF.md
# 1-Wire Byte and Search Triplet Sequencer

This block sits between a command decoder and a timed bit-slot engine on a 1-Wire master. It accepts one command at a time and breaks it into an ordered series of slot requests:
- a lone bit;
- eight write slots carrying a byte;
- eight read slots that assemble a byte;
- a three-slot search triplet;
- a bus reset.

As the slot engine reports each sample, the block gathers the results into a single-bit result flag, a second-bit flag, a branch-direction flag and a read-data byte. It keeps a busy flag for the whole operation. It also tells the slot engine on which slot a strong pullup should follow.

The search triplet reads two bits. It then decides the bit to write from those two samples and from a preferred direction supplied by the host in the top bit of the argument. In this way a host can walk a search tree one branch per command.

The controller has three states. IDLE waits for a command. ISSUE holds a slot request until the engine acknowledges it. WAIT waits for that slot's done pulse. The transitions are:
- IDLE→ISSUE when a command is accepted.
- ISSUE→WAIT on acknowledge.
- WAIT→ISSUE on done when slots remain.
- WAIT→ISSUE also on done of the final slot, when a new command is accepted in that same cycle (chaining).
- WAIT→IDLE on done of the final slot otherwise.

Top module: `owseq_top`

## Requirements
- R1: After reset, `busy`, `slot_req`, `slot_spu`, `sbr`, `tsb`, `dir` are 0 and `rdata` is 0.
- R2: Command code 1 (byte write) issues eight slots whose kind equals argument bit i on slot i, least significant bit first; kind code 0 = write-zero, 1 = write-one/read, 2 = bus reset.
- R3: Command code 2 (byte read) issues eight kind-1 slots. When it ends, `rdata` bit i holds the sample of slot i.
- R4: Command code 0 (single bit) issues one slot of kind equal to argument bit 7, and `sbr` then holds that slot's sample.
- R5: Command code 3 (triplet) issues two kind-1 slots, storing the first sample in `sbr` and the second in `tsb`, then a third slot. For samples (first,second) = (0,0) the third slot's kind is argument bit 7, for (0,1) it is 0, and for (1,x) it is 1. `dir` then holds the kind written.
- R6: `tsb` and `dir` change only during a triplet. `sbr` changes only during a single bit or a triplet. `rdata` changes only during a byte read.
- R7: `busy` is 1 from the cycle after a command is accepted until the final slot's done pulse. It is 0 in the cycle that pulse is high. A byte command uses 8 slots, a triplet 3, a single bit 1, and command code 4 (bus reset) one kind-2 slot.
- R8: `slot_req` stays high with a stable `slot_kind` until `slot_ack` is seen.
- R9: `slot_spu` is high only together with the request of the final slot of a single bit or byte write whose `cmd_spu` was 1 at acceptance. It is never high for a read, triplet or bus reset.
- R10: A command is taken when `cmd_valid` is 1, `busy` is 0 and the code is 0 to 4. Codes 5 to 7, or any command while busy, are ignored. A command presented in the cycle of the final done pulse starts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (0 bit, 1 write byte, 2 read byte, 3 triplet, 4 bus reset) |
| cmd_arg | input | DATA_W | Command argument (data byte, bit value or preferred direction in the top bit) |
| cmd_spu | input | 1 | Request strong pullup after the final slot |
| slot_req | output | 1 | Slot request to the slot engine |
| slot_kind | output | 2 | Slot kind: 0 write-zero, 1 write-one/read, 2 bus reset |
| slot_spu | output | 1 | Strong pullup to follow this slot |
| slot_ack | input | 1 | Slot engine has taken the request |
| slot_done | input | 1 | Slot finished pulse |
| slot_sample | input | 1 | Line sample of the finished slot |
| busy | output | 1 | Operation in progress |
| sbr | output | 1 | Single-bit or first triplet sample |
| tsb | output | 1 | Second triplet sample |
| dir | output | 1 | Direction written by the triplet |
| rdata | output | DATA_W | Byte assembled by a read |

## Verification
Two functions can meet in the same cycle: the capture of the final slot's result and the acceptance of the next command. The next command is taken because `busy` falls combinationally with the final done pulse. The bench provokes this by raising `cmd_valid` for a byte read in exactly the cycle that its slot model delivers the last done pulse of a byte write. It then judges that the write's eight slot kinds come out unbroken. It also judges that the read starts with no idle cycle, issues eight read slots and assembles the expected byte, and that `busy` reads 0 in the shared cycle. A separate case raises a command in mid-operation, to show that such a command does not disturb the running write.

// File: rtl/owseq_pkg.sv
package owseq_pkg;

    typedef enum logic [2:0] {
        OP_BIT     = 3'd0,
        OP_WRBYTE  = 3'd1,
        OP_RDBYTE  = 3'd2,
        OP_TRIPLET = 3'd3,
        OP_BUSRST  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        SK_ZERO  = 2'd0,
        SK_ONE   = 2'd1,
        SK_RESET = 2'd2
    } slot_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } st_e;

    localparam int TRIPLET_SLOTS = 3;
    localparam logic [2:0] OP_LAST_CODE = 3'd4;

endpackage

// File: rtl/owseq_decide.sv
module owseq_decide (
    input  logic first_smp,
    input  logic second_smp,
    input  logic pref_dir,
    output logic take_dir
);

    // Both branches present: follow the host preference.
    // Only the zero branch (first 0, complement 1): go zero.
    // Otherwise the one branch exists or nothing answered: go one.
    always_comb begin
        unique case ({first_smp, second_smp})
            2'b00:   take_dir = pref_dir;
            2'b01:   take_dir = 1'b0;
            default: take_dir = 1'b1;
        endcase
    end

endmodule

// File: rtl/owseq_txreg.sv
module owseq_txreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] arg,
    input  logic              shift,
    output logic              lsb,
    output logic              msb
);

    logic [DATA_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= arg;
        end else if (shift) begin
            q <= {1'b0, q[DATA_W-1:1]};
        end
    end

    assign lsb = q[0];
    assign msb = q[DATA_W-1];

endmodule

// File: rtl/owseq_ctrl.sv
module owseq_ctrl
    import owseq_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int IDX_W  = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic             cmd_spu,
    input  logic             slot_ack,
    input  logic             slot_done,
    input  logic             tx_lsb,
    input  logic             arg_msb,
    input  logic             trip_dir,
    output logic             busy,
    output logic             active,
    output logic             accept,
    output logic             done_evt,
    output logic             last_slot,
    output op_e              op_q,
    output logic [IDX_W-1:0] idx_q,
    output logic             slot_req,
    output logic [1:0]       slot_kind,
    output logic             slot_spu
);

    localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] LAST_TRIP = IDX_W'(TRIPLET_SLOTS - 1);

    st_e   st_q, st_d;
    logic  spu_q;
    logic  op_ok;
    slot_e kind_w;

    // final-slot decode from the latched command
    always_comb begin
        unique case (op_q)
            OP_WRBYTE, OP_RDBYTE: last_slot = (idx_q == LAST_BYTE);
            OP_TRIPLET:           last_slot = (idx_q == LAST_TRIP);
            default:              last_slot = 1'b1;
        endcase
    end

    assign active   = (st_q != ST_IDLE);
    assign done_evt = (st_q == ST_WAIT) && slot_done;
    assign busy     = active && !(done_evt && last_slot);
    assign op_ok    = (cmd_op <= OP_LAST_CODE);
    assign accept   = cmd_valid && op_ok && !busy;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) st_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (slot_ack) st_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (slot_done) begin
                    if (!last_slot || accept) st_d = ST_ISSUE;
                    else                      st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // latched command context and slot index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_BIT;
            spu_q <= 1'b0;
            idx_q <= '0;
        end else if (accept) begin
            op_q  <= op_e'(cmd_op);
            spu_q <= cmd_spu;
            idx_q <= '0;
        end else if (done_evt && !last_slot) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // outputs toward the slot engine
    always_comb begin
        slot_req = (st_q == ST_ISSUE);
        unique case (op_q)
            OP_BIT:     kind_w = arg_msb ? SK_ONE : SK_ZERO;
            OP_WRBYTE:  kind_w = tx_lsb ? SK_ONE : SK_ZERO;
            OP_RDBYTE:  kind_w = SK_ONE;
            OP_TRIPLET: kind_w = (idx_q == LAST_TRIP) ? (trip_dir ? SK_ONE : SK_ZERO) : SK_ONE;
            OP_BUSRST:  kind_w = SK_RESET;
            default:    kind_w = SK_ONE;
        endcase
        slot_spu = slot_req && last_slot && spu_q &&
                   ((op_q == OP_BIT) || (op_q == OP_WRBYTE));
    end

    assign slot_kind = kind_w;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req && !slot_ack |=> slot_req && $stable(slot_kind)); // R8

    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt && last_slot && !accept |=> !busy && !slot_req); // R7

    AST_CHAIN_START: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt && last_slot && accept |=> slot_req && (idx_q == '0)); // R10

endmodule

// File: rtl/owseq_result.sv
module owseq_result
    import owseq_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_evt,
    input  logic              active,
    input  op_e               op_q,
    input  logic [IDX_W-1:0]  idx_q,
    input  logic              sample,
    input  logic              trip_dir,
    output logic              sbr,
    output logic              tsb,
    output logic              dir,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sbr   <= 1'b0;
            tsb   <= 1'b0;
            dir   <= 1'b0;
            rdata <= '0;
        end else if (done_evt) begin
            case (op_q)
                OP_BIT: sbr <= sample;
                OP_RDBYTE: rdata <= {sample, rdata[DATA_W-1:1]};
                OP_TRIPLET: begin
                    if (idx_q == '0)               sbr <= sample;
                    else if (idx_q == IDX_W'(1))   tsb <= sample;
                    else                           dir <= trip_dir;
                end
                default: ;
            endcase
        end
    end

    AST_SBR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && (op_q == OP_BIT || op_q == OP_TRIPLET)) |=> $stable(sbr)); // R6

    AST_TSB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && op_q == OP_TRIPLET) |=> $stable(tsb)); // R6

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && op_q == OP_TRIPLET) |=> $stable(dir)); // R6

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && op_q == OP_RDBYTE) |=> $stable(rdata)); // R6

endmodule

// File: rtl/owseq_top.sv
module owseq_top
    import owseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_arg,
    input  logic              cmd_spu,
    output logic              slot_req,
    output logic [1:0]        slot_kind,
    output logic              slot_spu,
    input  logic              slot_ack,
    input  logic              slot_done,
    input  logic              slot_sample,
    output logic              busy,
    output logic              sbr,
    output logic              tsb,
    output logic              dir,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W = $clog2(DATA_W);

    logic             active, accept, done_evt, last_slot;
    op_e              op_q;
    logic [IDX_W-1:0] idx_q;
    logic             tx_lsb, arg_msb, trip_dir, tx_shift;

    assign tx_shift = done_evt && (op_q == OP_WRBYTE);

    owseq_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_spu   (cmd_spu),
        .slot_ack  (slot_ack),
        .slot_done (slot_done),
        .tx_lsb    (tx_lsb),
        .arg_msb   (arg_msb),
        .trip_dir  (trip_dir),
        .busy      (busy),
        .active    (active),
        .accept    (accept),
        .done_evt  (done_evt),
        .last_slot (last_slot),
        .op_q      (op_q),
        .idx_q     (idx_q),
        .slot_req  (slot_req),
        .slot_kind (slot_kind),
        .slot_spu  (slot_spu)
    );

    owseq_txreg #(.DATA_W(DATA_W)) txreg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .arg   (cmd_arg),
        .shift (tx_shift),
        .lsb   (tx_lsb),
        .msb   (arg_msb)
    );

    owseq_decide decide_i (
        .first_smp  (sbr),
        .second_smp (tsb),
        .pref_dir   (arg_msb),
        .take_dir   (trip_dir)
    );

    owseq_result #(.DATA_W(DATA_W)) result_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_evt (done_evt),
        .active   (active),
        .op_q     (op_q),
        .idx_q    (idx_q),
        .sample   (slot_sample),
        .trip_dir (trip_dir),
        .sbr      (sbr),
        .tsb      (tsb),
        .dir      (dir),
        .rdata    (rdata)
    );

endmodule

// File: tb/owseq_tb_top.sv
module owseq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic [7:0] cmd_arg;
    logic       cmd_spu;
    logic       slot_req, slot_spu, slot_ack, slot_done, slot_sample;
    logic [1:0] slot_kind;
    logic       busy, sbr, tsb, dir;
    logic [7:0] rdata;

    always #5 clk = ~clk;

    owseq_top #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .cmd_spu(cmd_spu), .slot_req(slot_req),
        .slot_kind(slot_kind), .slot_spu(slot_spu), .slot_ack(slot_ack),
        .slot_done(slot_done), .slot_sample(slot_sample), .busy(busy),
        .sbr(sbr), .tsb(tsb), .dir(dir), .rdata(rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] kind_log [0:31];
    logic       spu_log  [0:31];
    logic       resp     [0:31];
    int   slot_cnt  = 0;
    int   exp_slots = 0;
    int   chain_at  = -1;
    logic chain_en  = 1'b0;
    logic [2:0] chain_op = 3'd0;
    logic fired = 1'b0;
    logic m_sbr = 0, m_tsb = 0, m_dir = 0;
    logic [7:0] m_rdata = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] kinds_packed(input int n);
        logic [31:0] p = '0;
        for (int i = 0; i < n; i++) p[2*i +: 2] = kind_log[i];
        return p;
    endfunction

    function automatic logic [15:0] spus_packed(input int n);
        logic [15:0] p = '0;
        for (int i = 0; i < n; i++) p[i] = spu_log[i];
        return p;
    endfunction

    // behavioural slot engine
    initial begin : slot_engine
        int k;
        slot_ack = 0; slot_done = 0; slot_sample = 0;
        forever begin
            @(negedge clk);
            if (slot_req === 1'b1) begin
                k = slot_cnt & 31;
                kind_log[k] = slot_kind;
                spu_log[k]  = slot_spu;
                repeat (slot_cnt % 2) begin
                    @(negedge clk);
                    chk("R8", "request held",
                        {29'd0, slot_req, slot_kind}, {29'd0, 1'b1, kind_log[k]});
                end
                slot_ack = 1;
                @(negedge clk);
                slot_ack = 0;
                repeat (1 + slot_cnt % 3) @(negedge clk);
                slot_sample = (kind_log[k] == 2'd1) ? resp[k] : 1'b0;
                slot_done = 1;
                slot_cnt = slot_cnt + 1;
                if (chain_en && slot_cnt == chain_at) begin
                    cmd_valid = 1; cmd_op = chain_op; cmd_arg = 8'h00; cmd_spu = 0;
                    chain_en = 0; fired = 1;
                end
                #1;
                chk("R7", "busy at slot done", {31'd0, busy},
                    (slot_cnt == exp_slots || slot_cnt == chain_at) ? 32'd0 : 32'd1);
                @(negedge clk);
                slot_done = 0; slot_sample = 0;
                if (fired) begin cmd_valid = 0; fired = 0; end
            end
        end
    end

    task automatic start_cmd(input logic [2:0] op, input logic [7:0] arg,
                             input logic spu, input int nslots);
        slot_cnt = 0; exp_slots = nslots;
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_arg = arg; cmd_spu = spu;
        @(negedge clk);
        cmd_valid = 0;
        #2;
        chk("R7", "busy after accept", {31'd0, busy}, 32'd1);
    endtask

    task automatic finish_cmd();
        while (!(slot_cnt >= exp_slots && busy == 1'b0)) begin
            @(negedge clk); #2;
        end
        @(negedge clk); #2;
        chk("R7", "slot count", slot_cnt, exp_slots);
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [7:0] arg,
                           input logic spu, input int nslots);
        chain_at = -1;
        start_cmd(op, arg, spu, nslots);
        finish_cmd();
    endtask

    task automatic chk_results();
        chk("R6", "sbr", {31'd0, sbr}, {31'd0, m_sbr});
        chk("R6", "tsb", {31'd0, tsb}, {31'd0, m_tsb});
        chk("R6", "dir", {31'd0, dir}, {31'd0, m_dir});
        chk("R6", "rdata", {24'd0, rdata}, {24'd0, m_rdata});
    endtask

    initial begin : main
        logic [31:0] ek;
        logic r0, r1, pf, tk, spu;
        for (int i = 0; i < 32; i++) resp[i] = 1'b0;
        rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_arg = 0; cmd_spu = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        chk("R1", "reset outputs",
            {20'd0, busy, slot_req, slot_spu, sbr, tsb, dir, rdata}, 32'd0);

        // R2 byte write sweep
        for (int v = 0; v < 256; v++) begin
            spu = v[0] ^ v[3];
            run_cmd(3'd1, v[7:0], spu, 8);
            ek = '0;
            for (int i = 0; i < 8; i++) ek[2*i +: 2] = {1'b0, v[i]};
            chk("R2", "write slot kinds", kinds_packed(8), ek);
            chk("R9", "write spu slots", {16'd0, spus_packed(8)}, {24'd0, spu, 7'd0});
            chk_results();
        end

        // R3 byte read sweep
        for (int v = 0; v < 256; v++) begin
            for (int i = 0; i < 8; i++) resp[i] = v[i];
            run_cmd(3'd2, 8'hFF ^ v[7:0], 1'b1, 8);
            chk("R3", "read slot kinds", kinds_packed(8), 32'h0000_5555);
            chk("R9", "read spu never", {16'd0, spus_packed(8)}, 32'd0);
            m_rdata = v[7:0];
            chk("R3", "read data", {24'd0, rdata}, {24'd0, m_rdata});
            chk_results();
        end

        // R4 single bit
        for (int c = 0; c < 8; c++) begin
            resp[0] = c[1];
            run_cmd(3'd0, {c[0], 7'h2A}, c[2], 1);
            chk("R4", "single kind", kinds_packed(1), {31'd0, c[0]});
            chk("R9", "single spu", {16'd0, spus_packed(1)}, {31'd0, c[2]});
            m_sbr = c[0] & c[1];
            chk("R4", "single sbr", {31'd0, sbr}, {31'd0, m_sbr});
            chk_results();
        end

        // R5 triplet, all sample/preference combinations
        for (int c = 0; c < 8; c++) begin
            r0 = c[0]; r1 = c[1]; pf = c[2];
            tk = r0 ? 1'b1 : (r1 ? 1'b0 : pf);
            resp[0] = r0; resp[1] = r1; resp[2] = 1'b1;
            run_cmd(3'd3, {pf, 7'h15}, 1'b1, 3);
            chk("R5", "triplet kinds", kinds_packed(3), {26'd0, 1'b0, tk, 4'b0101});
            chk("R9", "triplet spu never", {16'd0, spus_packed(3)}, 32'd0);
            m_sbr = r0; m_tsb = r1; m_dir = tk;
            chk("R5", "triplet flags", {29'd0, sbr, tsb, dir}, {29'd0, r0, r1, tk});
            chk_results();
        end

        // bus reset: one reset slot
        run_cmd(3'd4, 8'h80, 1'b1, 1);
        chk("R7", "bus reset kind", kinds_packed(1), 32'd2);
        chk("R9", "bus reset spu never", {16'd0, spus_packed(1)}, 32'd0);
        chk_results();

        // R10 command while busy is ignored
        chain_at = -1;
        start_cmd(3'd1, 8'hA5, 1'b0, 8);
        while (slot_cnt < 2) begin @(negedge clk); #2; end
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'd2; cmd_arg = 8'h00; cmd_spu = 1;
        @(negedge clk);
        cmd_valid = 0;
        finish_cmd();
        repeat (20) @(negedge clk);
        #2;
        chk("R10", "busy command ignored, slot count", slot_cnt, 8);
        chk("R10", "running write intact", kinds_packed(8), 32'h0000_4411);
        chk_results();

        // R10 unused code ignored
        slot_cnt = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'd5; cmd_arg = 8'hFF; cmd_spu = 1;
        @(negedge clk);
        cmd_valid = 0;
        repeat (10) @(negedge clk);
        #2;
        chk("R10", "unused code: no slot, not busy", {slot_cnt[30:0], busy}, 32'd0);
        chk_results();

        // R10 chaining: read presented in the final done cycle of a write
        for (int i = 0; i < 8; i++) resp[8 + i] = 8'hC6 >> i;
        chain_at = 8; chain_op = 3'd2; chain_en = 1;
        start_cmd(3'd1, 8'h3C, 1'b1, 16);
        finish_cmd();
        chk("R10", "chained kinds", kinds_packed(16), 32'h5555_0550);
        chk("R9", "chained spu", {16'd0, spus_packed(16)}, 32'h0000_0080);
        m_rdata = 8'hC6;
        chk("R10", "chained read data", {24'd0, rdata}, 32'h0000_00C6);
        chk_results();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R7 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule